// File: doc/BRIEF.md
# Priority Interrupt Controller with Global Enable

This block arbitrates interrupts for a small 8-bit processor core. It takes two kinds of source. Event sources are single-cycle pulses that set a sticky flag. Level sources ask for service only while their input is high, and they keep no memory. The block holds the global enable bit, one enable bit per source and the event flags. From the pending sources that are enabled, it picks the one with the lowest index. It then presents a registered request strobe and a 5-bit vector index to the core.

The core reports its own activity through one-cycle strobes:
- an instruction boundary;
- interrupt acceptance (acknowledge);
- return from interrupt;
- set global enable;
- clear global enable.

The block applies the global-enable side effects of each strobe. Clearing the global enable works at once. Setting it, or returning from a handler, holds back every request until the core reports one more completed instruction. Software writes the enable register and clears flags through plain write strobes.

The request/acknowledge pair is not a buffered stream. The request is recomputed every cycle and can drop without an acknowledge, for example when a level source goes away or the global enable is cleared. The core acknowledges only in a cycle where `irq_req_o` is high, and it takes `irq_vec_o` from that same cycle.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, `irq_req_o`, `gie_o`, `flags_o`, `en_o` and `irq_vec_o` are all zero.
- R2: An `evt_i[i]` pulse sets `flags_o[i]` on the next cycle, whether or not the source enable or the global enable is set. The flag stays set until it is cleared.
- R3: When `flag_clr_we_i` is high, each `flag_clr_i` bit that is 1 clears its flag and each bit that is 0 leaves its flag unchanged. An event in the same cycle as a clear (software clear or acknowledge) keeps the flag set.
- R4: `irq_req_o` is high in a cycle only if, at the preceding edge, the global enable was on, no post-enable guard was active, and at least one enabled source was pending. Event source i maps to vector i. Level source j maps to vector NUM_EVT+j.
- R5: An `ack_i` pulse clears the global enable. It also clears the flag of the event source named by `irq_vec_o`, and `irq_req_o` is low on the next cycle.
- R6: A level source requests only while its input is high and enabled. A level input that rises and falls while disabled is never served.
- R7: `cli_i` clears the global enable on the next cycle and forces `irq_req_o` low, even when an event arrives in the same cycle. `cli_i` overrides `sei_i`, `reti_i` and `ack_i`.
- R8: `sei_i` or `reti_i` (without `cli_i`/`ack_i`) sets the global enable. No request is raised until an `instr_done_i` strobe arrives in a later cycle.
- R9: Setting the global enable inside a handler lets another pending enabled source be requested, so handlers can nest.
- R10: When `en_we_i` is high, `en_o` takes `en_wdata_i` on the next cycle. Bit i is the enable of vector i.
- R11: When several enabled sources are pending, the lowest vector index is presented. They are served one per acknowledge in ascending index order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT | Event pulses, one per flag source |
| lvl_i | input | NUM_LVL | Level request inputs |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | NUM_EVT+NUM_LVL | Enable register write data |
| flag_clr_we_i | input | 1 | Flag clear strobe |
| flag_clr_i | input | NUM_EVT | Write-one-to-clear flag mask |
| sei_i | input | 1 | Set-global-enable instruction executed |
| cli_i | input | 1 | Clear-global-enable instruction executed |
| reti_i | input | 1 | Return-from-interrupt executed |
| instr_done_i | input | 1 | Main-program instruction completed |
| ack_i | input | 1 | Core accepts the presented interrupt |
| irq_req_o | output | 1 | Registered interrupt request |
| irq_vec_o | output | 5 | Vector index of the presented request |
| gie_o | output | 1 | Global enable state |
| flags_o | output | NUM_EVT | Event flags |
| en_o | output | NUM_EVT+NUM_LVL | Per-source enables |

## Verification
The assertions check the following on every cycle:
- a request never appears without the global enable;
- acknowledge and clear-enable always drop the request;
- set-enable and return always open the one-instruction guard;
- events always stick;
- write-one-to-clear never clears a bit with a concurrent event;
- enable writes land.

Some behaviour shows only in the bench's scenarios and its reference model:
- which vector wins, and in what order nested or queued sources are served;
- that a level pulse seen while disabled is forgotten;
- that the guard lifts on exactly the first later instruction strobe.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned VEC_W = 5;
  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic sei;
    logic cli;
    logic reti;
    logic ack;
    logic instr_done;
  } core_evt_t;
endpackage

// File: rtl/pic_gie_ctrl.sv
module pic_gie_ctrl
  import pic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  core_evt_t ev,
  output logic      gie_q,
  output logic      gie_n,
  output logic      hold_n
);
  logic hold_q;

  // Clearing wins over everything, acceptance wins over setting.
  always_comb begin
    gie_n = gie_q;
    if (ev.cli)                 gie_n = 1'b0;
    else if (ev.ack)            gie_n = 1'b0;
    else if (ev.sei || ev.reti) gie_n = 1'b1;
  end

  // One-instruction guard: armed by set/return, released by a later boundary.
  always_comb begin
    hold_n = hold_q;
    if (ev.sei || ev.reti)  hold_n = 1'b1;
    else if (ev.instr_done) hold_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      gie_q  <= gie_n;
      hold_q <= hold_n;
    end
  end
endmodule

// File: rtl/pic_src_bank.sv
module pic_src_bank
  import pic_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned NUM_LVL = 4,
  localparam int unsigned NSRC = NUM_EVT + NUM_LVL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               en_we,
  input  logic [NSRC-1:0]    en_wdata,
  input  logic               clr_we,
  input  logic [NUM_EVT-1:0] clr_bits,
  input  logic               ack,
  input  vec_t               ack_vec,
  output logic [NUM_EVT-1:0] flag_q,
  output logic [NUM_EVT-1:0] flag_n,
  output logic [NSRC-1:0]    en_q,
  output logic [NSRC-1:0]    en_n
);
  genvar g;
  generate
    for (g = 0; g < NUM_EVT; g++) begin : g_flag
      logic hw_clr;
      logic sw_clr;
      assign hw_clr = ack && (ack_vec == VEC_W'(g));
      assign sw_clr = clr_we && clr_bits[g];
      // A fresh event beats any clear in the same cycle.
      assign flag_n[g] = evt[g] | (flag_q[g] & ~hw_clr & ~sw_clr);
    end
  endgenerate

  assign en_n = en_we ? en_wdata : en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_n;
      en_q   <= en_n;
    end
  end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc
  import pic_pkg::*;
#(
  parameter int unsigned NSRC = 12
) (
  input  logic [NSRC-1:0] pend,
  output logic            any,
  output vec_t            idx
);
  // Scan from the top down so the lowest pending index is kept last.
  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = VEC_W'(i);
    end
  end

  assign any = |pend;
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned NUM_LVL = 4,
  localparam int unsigned NSRC = NUM_EVT + NUM_LVL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_LVL-1:0] lvl_i,
  input  logic               en_we_i,
  input  logic [NSRC-1:0]    en_wdata_i,
  input  logic               flag_clr_we_i,
  input  logic [NUM_EVT-1:0] flag_clr_i,
  input  logic               sei_i,
  input  logic               cli_i,
  input  logic               reti_i,
  input  logic               instr_done_i,
  input  logic               ack_i,
  output logic               irq_req_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic               gie_o,
  output logic [NUM_EVT-1:0] flags_o,
  output logic [NSRC-1:0]    en_o
);
  core_evt_t          ev;
  logic               gie_q, gie_n, hold_n;
  logic [NUM_EVT-1:0] flag_q, flag_n;
  logic [NSRC-1:0]    en_q, en_n;
  logic [NSRC-1:0]    pend_n;
  logic               any_n;
  vec_t               idx_n;
  logic               req_q;
  vec_t               vec_q;

  assign ev = '{sei: sei_i, cli: cli_i, reti: reti_i, ack: ack_i,
                instr_done: instr_done_i};

  pic_gie_ctrl u_gie (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev),
    .gie_q  (gie_q),
    .gie_n  (gie_n),
    .hold_n (hold_n)
  );

  pic_src_bank #(.NUM_EVT(NUM_EVT), .NUM_LVL(NUM_LVL)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_i),
    .en_we    (en_we_i),
    .en_wdata (en_wdata_i),
    .clr_we   (flag_clr_we_i),
    .clr_bits (flag_clr_i),
    .ack      (ack_i),
    .ack_vec  (vec_q),
    .flag_q   (flag_q),
    .flag_n   (flag_n),
    .en_q     (en_q),
    .en_n     (en_n)
  );

  // Event sources occupy the low vectors, level sources follow them.
  assign pend_n = {lvl_i & en_n[NSRC-1:NUM_EVT], flag_n & en_n[NUM_EVT-1:0]};

  pic_prio_enc #(.NSRC(NSRC)) u_enc (
    .pend (pend_n),
    .any  (any_n),
    .idx  (idx_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= gie_n && !hold_n && any_n;
      vec_q <= idx_n;
    end
  end

  assign irq_req_o = req_q;
  assign irq_vec_o = vec_q;
  assign gie_o     = gie_q;
  assign flags_o   = flag_q;
  assign en_o      = en_q;
endmodule

// File: rtl/pic_ctrl_checker.sv
module pic_ctrl_checker
  import pic_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned NUM_LVL = 4,
  localparam int unsigned NSRC = NUM_EVT + NUM_LVL
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               en_we_i,
  input logic [NSRC-1:0]    en_wdata_i,
  input logic               flag_clr_we_i,
  input logic [NUM_EVT-1:0] flag_clr_i,
  input logic               sei_i,
  input logic               cli_i,
  input logic               reti_i,
  input logic               ack_i,
  input logic               irq_req_o,
  input logic [VEC_W-1:0]   irq_vec_o,
  input logic               gie_o,
  input logic [NUM_EVT-1:0] flags_o,
  input logic [NSRC-1:0]    en_o
);
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> gie_o); // R4
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_vec_o < VEC_W'(NSRC))); // R4
  AST_ACK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> (!gie_o && !irq_req_o)); // R5
  AST_CLI_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    cli_i |=> (!gie_o && !irq_req_o)); // R7
  AST_SET_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    ((sei_i || reti_i) && !cli_i && !ack_i) |=> (gie_o && !irq_req_o)); // R8
  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_o & $past(evt_i)) == $past(evt_i))); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_we_i |=> ((flags_o & $past(flag_clr_i & ~evt_i)) == '0)); // R3
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    en_we_i |=> (en_o == $past(en_wdata_i))); // R10
endmodule

bind pic_ctrl pic_ctrl_checker #(.NUM_EVT(NUM_EVT), .NUM_LVL(NUM_LVL)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_i        (evt_i),
  .en_we_i      (en_we_i),
  .en_wdata_i   (en_wdata_i),
  .flag_clr_we_i(flag_clr_we_i),
  .flag_clr_i   (flag_clr_i),
  .sei_i        (sei_i),
  .cli_i        (cli_i),
  .reti_i       (reti_i),
  .ack_i        (ack_i),
  .irq_req_o    (irq_req_o),
  .irq_vec_o    (irq_vec_o),
  .gie_o        (gie_o),
  .flags_o      (flags_o),
  .en_o         (en_o)
);

// File: tb/sim_pic_ctrl.sv
module sim_pic_ctrl;
  localparam int NE = 8;
  localparam int NL = 4;
  localparam int NS = NE + NL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt_i = '0;
  logic [NL-1:0] lvl_i = '0;
  logic          en_we_i = 1'b0;
  logic [NS-1:0] en_wdata_i = '0;
  logic          flag_clr_we_i = 1'b0;
  logic [NE-1:0] flag_clr_i = '0;
  logic          sei_i = 1'b0, cli_i = 1'b0, reti_i = 1'b0;
  logic          instr_done_i = 1'b0, ack_i = 1'b0;
  logic          irq_req_o;
  logic [4:0]    irq_vec_o;
  logic          gie_o;
  logic [NE-1:0] flags_o;
  logic [NS-1:0] en_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pic_ctrl #(.NUM_EVT(NE), .NUM_LVL(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .lvl_i(lvl_i),
    .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
    .flag_clr_we_i(flag_clr_we_i), .flag_clr_i(flag_clr_i),
    .sei_i(sei_i), .cli_i(cli_i), .reti_i(reti_i),
    .instr_done_i(instr_done_i), .ack_i(ack_i),
    .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .gie_o(gie_o),
    .flags_o(flags_o), .en_o(en_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  // Behavioural reference model, stepped at each rising edge.
  bit          m_gie, m_hold, m_req;
  bit [NE-1:0] m_flag;
  bit [NS-1:0] m_en;
  int          m_vec;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gie = 0; m_hold = 0; m_req = 0; m_flag = '0; m_en = '0; m_vec = 0;
    end else begin
      int win;
      bit p;
      if (cli_i || ack_i) m_gie = 0;
      else if (sei_i || reti_i) m_gie = 1;
      if (sei_i || reti_i) m_hold = 1;
      else if (instr_done_i) m_hold = 0;
      for (int i = 0; i < NE; i++) begin
        if (evt_i[i]) m_flag[i] = 1;
        else if ((flag_clr_we_i && flag_clr_i[i]) || (ack_i && m_vec == i)) m_flag[i] = 0;
      end
      if (en_we_i) m_en = en_wdata_i;
      win = -1;
      for (int i = 0; i < NS; i++) begin
        p = (i < NE) ? (m_flag[i] & m_en[i]) : (lvl_i[i-NE] & m_en[i]);
        if (p && win < 0) win = i;
      end
      m_req = m_gie && !m_hold && (win >= 0);
      m_vec = (win < 0) ? 0 : win;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(irq_req_o == m_req, "R4 model irq_req", irq_req_o, m_req);
      chk(int'(irq_vec_o) == m_vec, "R11 model irq_vec", irq_vec_o, m_vec);
      chk(gie_o == m_gie, "R8 model gie", gie_o, m_gie);
      chk(flags_o == m_flag, "R2 model flags", flags_o, m_flag);
      chk(en_o == m_en, "R10 model en", en_o, m_en);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    evt_i = '0; en_we_i = 0; flag_clr_we_i = 0; flag_clr_i = '0;
    sei_i = 0; cli_i = 0; reti_i = 0; instr_done_i = 0; ack_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    chk(!irq_req_o && !gie_o && flags_o == 0 && en_o == 0 && irq_vec_o == 0,
        "R1 reset state", {irq_req_o, gie_o, flags_o}, 0);

    // R2 events latch while everything is disabled
    evt_i = 8'h0C; tick();
    chk(flags_o == 8'h0C, "R2 flag set while disabled", flags_o, 8'h0C);
    chk(!irq_req_o, "R2 no request while disabled", irq_req_o, 0);

    // R3 write-one-to-clear, zero bits unchanged
    flag_clr_we_i = 1; flag_clr_i = 8'h08; tick();
    chk(flags_o == 8'h04, "R3 clear one bit", flags_o, 8'h04);
    // R3 event wins over same-cycle clear
    flag_clr_we_i = 1; flag_clr_i = 8'h04; evt_i = 8'h24; tick();
    chk(flags_o == 8'h24, "R3 event beats clear", flags_o, 8'h24);

    // R10 enable write, bit i = vector i
    en_we_i = 1; en_wdata_i = 12'h02C; tick();
    chk(en_o == 12'h02C, "R10 enable write", en_o, 12'h02C);

    // R8 guard after set-enable
    sei_i = 1; tick();
    chk(gie_o && !irq_req_o, "R8 guard after sei", irq_req_o, 0);
    tick();
    chk(!irq_req_o, "R8 guard holds without boundary", irq_req_o, 0);
    instr_done_i = 1; tick();
    chk(irq_req_o && irq_vec_o == 2, "R4 R11 lowest vector", irq_vec_o, 2);

    // R5 acknowledge
    ack_i = 1; tick();
    chk(!gie_o && !irq_req_o && flags_o == 8'h20, "R5 ack clears gie and flag", flags_o, 8'h20);

    // R9 nesting inside a handler
    sei_i = 1; tick();
    instr_done_i = 1; tick();
    chk(irq_req_o && irq_vec_o == 5, "R9 nested request", irq_vec_o, 5);
    ack_i = 1; tick();
    chk(flags_o == 0 && !gie_o, "R5 nested ack", flags_o, 0);

    // R8 return sets enable with guard
    reti_i = 1; tick();
    chk(gie_o && !irq_req_o, "R8 reti sets gie", gie_o, 1);
    instr_done_i = 1; tick();
    chk(!irq_req_o, "R4 nothing pending", irq_req_o, 0);

    // R6 level source
    en_we_i = 1; en_wdata_i = 12'h22C; tick();
    lvl_i = 4'b0010; tick();
    chk(irq_req_o && irq_vec_o == 9, "R6 level request", irq_vec_o, 9);
    lvl_i = 4'b0000; tick();
    chk(!irq_req_o, "R6 level removed", irq_req_o, 0);
    en_we_i = 1; en_wdata_i = 12'h02C; tick();
    lvl_i = 4'b0010; tick(); tick();
    lvl_i = 4'b0000; tick();
    en_we_i = 1; en_wdata_i = 12'h22C; tick(); tick();
    chk(!irq_req_o, "R6 vanished level not served", irq_req_o, 0);

    // R7 clear-enable with same-cycle event
    cli_i = 1; evt_i = 8'h08; tick();
    chk(!gie_o && !irq_req_o, "R7 cli masks same-cycle event", irq_req_o, 0);
    chk(flags_o == 8'h08, "R2 event kept under cli", flags_o, 8'h08);
    sei_i = 1; cli_i = 1; tick();
    chk(!gie_o, "R7 cli beats sei", gie_o, 0);

    // R11 queued sources served in order
    evt_i = 8'h04; tick();
    sei_i = 1; tick();
    instr_done_i = 1; tick();
    chk(irq_req_o && irq_vec_o == 2, "R11 first of two", irq_vec_o, 2);
    ack_i = 1; tick();
    chk(flags_o == 8'h08, "R11 first flag consumed", flags_o, 8'h08);
    reti_i = 1; tick();
    instr_done_i = 1; tick();
    chk(irq_req_o && irq_vec_o == 3, "R11 second of two", irq_vec_o, 3);
    ack_i = 1; tick();

    // Mixed traffic, compared against the model every cycle
    en_we_i = 1; en_wdata_i = 12'hFFF; tick();
    for (int c = 0; c < 3000; c++) begin
      evt_i = (($urandom % 4) == 0) ? NE'($urandom) : '0;
      if (($urandom % 8) == 0) lvl_i = NL'($urandom);
      flag_clr_we_i = (($urandom % 10) == 0);
      flag_clr_i = NE'($urandom);
      en_we_i = (($urandom % 40) == 0);
      en_wdata_i = NS'($urandom);
      instr_done_i = (($urandom % 2) == 0);
      ack_i = irq_req_o && (($urandom % 3) == 0);
      sei_i = !ack_i && (($urandom % 12) == 0);
      reti_i = !ack_i && !sei_i && (($urandom % 12) == 0);
      cli_i = (($urandom % 25) == 0);
      tick();
    end
    finish_run();
  end
endmodule